// File: doc/BRIEF.md
# Four-Channel Parallel DAC Bus Sequencer

This block sits on the host side of a quad 12-bit voltage-output converter that has a parallel bus. It takes one request at a time from a small valid/opcode interface and turns it into correctly timed pin activity. The pins are an active-low select, a read/write line, a 2-bit channel address, a 12-bit data bus with its own output enable, an active-low load strobe that moves input registers into output registers, and an active-low converter reset. Four request kinds exist: write one channel, write all four channels as a batch, read one channel back, and pulse the converter reset.

A mode input picks how the load strobe is used. In single-buffer mode the strobe falls together with select on every write and stays low for a hold time after select rises, so each output follows its data at once. In double-buffer mode writes leave the strobe high. A batch then ends with one stand-alone strobe pulse while select is high, so all four outputs change together. Every minimum width, setup and hold is given in nanoseconds and turned into clock cycles by ceiling division against the clock period.

The controller is a single state machine with these states. IDLE waits for a request. WRITE drives select low with data. LDHOLD keeps the strobe low after select rises, in single-buffer mode only. GAP holds select high between batch channels and before the batch load pulse. LOAD is the stand-alone strobe pulse. READ drives select low with the bus released. RESET drives the converter reset low. The transitions are as follows. IDLE goes to WRITE, READ or RESET when a request is accepted. WRITE goes to LDHOLD in single-buffer mode. In double-buffer mode WRITE goes to GAP when batch channels remain or the batch needs its load, and to IDLE otherwise. LDHOLD goes to GAP when channels remain and to IDLE otherwise. GAP goes to WRITE for the next channel, or to LOAD after the last channel of a double-buffer batch. LOAD, READ and RESET each return to IDLE.

Top module: `dacbus_seq`

## Requirements
- R1: After system reset and whenever busy is low, dac_cs_n, dac_ldac_n and dac_reset_n are high, dac_doe is low, busy is low and done is low.
- R2: A write drives dac_cs_n low with dac_rw low for exactly max(ceil(80 ns), ceil(70 ns)) cycles, which is 10 cycles at 8 ns. dac_addr carries the channel and dac_dout carries the data, both stable while select is low, and dac_doe is high.
- R3: In single-buffer mode (dbl_buf = 0) dac_ldac_n falls in the same cycle as dac_cs_n on every write. It stays low ceil(30 ns) cycles after select rises, for a total low time of 14 cycles, so the output follows the written data.
- R4: In double-buffer mode (dbl_buf = 1) a single-channel write leaves dac_ldac_n high. The channel's input register changes and its output does not.
- R5: A batch request (req_op = 1) writes channels 0, 1, 2, 3 in that address order, using the data at req_batch bits [12k+11:12k] for channel k. Between select pulses, select stays high for GAP_CYC cycles in double-buffer mode, or for hold plus GAP_CYC cycles in single-buffer mode.
- R6: In double-buffer mode a batch ends, after the last write and one gap, with exactly one dac_ldac_n low pulse of ceil(170 ns) = 22 cycles. dac_cs_n is high during that pulse, and all four outputs take the new values.
- R7: A read (req_op = 2) drives dac_cs_n low with dac_rw high for max(ceil(130 ns), ceil(160 ns)) = 20 cycles with dac_doe low. The value on dac_din in the last select-low cycle is captured and presented on rd_data together with done.
- R8: A reset request (req_op = 3) drives dac_reset_n low for ceil(140 ns) = 18 cycles with dac_cs_n and dac_ldac_n high.
- R9: A request is accepted on a clock edge where req_valid is high and busy is low. busy is high from the next cycle until the cycle in which the last strobe returns inactive. In that cycle busy is low and done pulses high for one cycle. Busy lasts 14 cycles for a single-buffer write, 10 for a double-buffer write, 62 and 70 for single- and double-buffer batches, 20 for a read and 18 for a reset.
- R10: A request presented while busy is high has no effect. It does not lengthen the operation in progress, does not cause an extra select pulse, and is not performed afterwards. Request opcodes: 0 write one channel, 1 batch write, 2 read, 3 converter reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset of the sequencer |
| dbl_buf | input | 1 | 1 = double-buffer mode, 0 = single-buffer mode; sampled at accept |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 write, 1 batch, 2 read, 3 converter reset |
| req_chan | input | 2 | Channel for write or read |
| req_data | input | 12 | Data for a single-channel write |
| req_batch | input | 48 | Batch data, channel k in bits [12k+11:12k] |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 12 | Value captured by the last read |
| dac_cs_n | output | 1 | Converter select, active low |
| dac_rw | output | 1 | 1 read, 0 write |
| dac_addr | output | 2 | Channel address |
| dac_dout | output | 12 | Data driven toward the converter |
| dac_doe | output | 1 | Data bus drive enable |
| dac_din | input | 12 | Data returned by the converter |
| dac_ldac_n | output | 1 | Load strobe, active low |
| dac_reset_n | output | 1 | Converter reset, active low |

## Verification
The bench drives the pins into a small behavioural converter that latches input registers when select rises, copies them to outputs while the load strobe is low, and answers reads. The corner cases it targets are listed here with the failure each would expose. In a double-buffer write alone, a design that pulses the strobe would change the output too early. In a double-buffer batch, a design that overlaps the strobe with select, or issues more than one pulse, would break the simultaneous update. In a single-buffer write, a design that releases the strobe with select would lose the hold time and show a short low width. A request held high during a busy write must not lengthen the write, add a select pulse or run later. If it did, a readback would return the intruding value. Reads check that the bus is released and that the value captured is the one present at the end of the pulse.

// File: rtl/dacbus_pkg.sv
package dacbus_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_BATCH = 2'd1,
        OP_READ  = 2'd2,
        OP_RESET = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_LDHOLD,
        ST_GAP,
        ST_LOAD,
        ST_READ,
        ST_RESET
    } state_e;

    // Minimum time in ns -> clock cycles, rounded up
    function automatic int ns_to_cyc(input int t_ns, input int clk_ps);
        return (t_ns * 1000 + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dacbus_timer.sv
module dacbus_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (count_q != '0) begin
            count_q <= count_q - CNT_W'(1);
        end
    end

    assign zero = (count_q == '0);

endmodule

// File: rtl/dacbus_stage.sv
module dacbus_stage #(
    parameter int DATA_W = 12,
    parameter int NCH    = 4,
    localparam int ADDR_W = $clog2(NCH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cap_all,
    input  logic                  cap_one,
    input  logic [ADDR_W-1:0]     cap_sel,
    input  logic [DATA_W-1:0]     one_data,
    input  logic [NCH*DATA_W-1:0] all_data,
    input  logic [ADDR_W-1:0]     rd_sel,
    output logic [DATA_W-1:0]     rd_data
);

    logic [DATA_W-1:0] slot_q [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_slot
        localparam logic [ADDR_W-1:0] IDX = ADDR_W'(g);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (cap_all) begin
                slot_q[g] <= all_data[g*DATA_W +: DATA_W];
            end else if (cap_one && (cap_sel == IDX)) begin
                slot_q[g] <= one_data;
            end
        end
    end

    assign rd_data = slot_q[rd_sel];

endmodule

// File: rtl/dacbus_seq.sv
module dacbus_seq
    import dacbus_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int NCH         = 4,
    parameter int CLK_PS      = 8000,
    parameter int T_WR_CS_NS  = 80,
    parameter int T_LD_SU_NS  = 70,
    parameter int T_LD_HD_NS  = 30,
    parameter int T_LD_PW_NS  = 170,
    parameter int T_RST_NS    = 140,
    parameter int T_RD_CS_NS  = 130,
    parameter int T_RD_ACC_NS = 160,
    parameter int GAP_CYC     = 2,
    localparam int ADDR_W = $clog2(NCH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  dbl_buf,
    input  logic                  req_valid,
    input  logic [1:0]            req_op,
    input  logic [ADDR_W-1:0]     req_chan,
    input  logic [DATA_W-1:0]     req_data,
    input  logic [NCH*DATA_W-1:0] req_batch,
    output logic                  busy,
    output logic                  done,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  dac_cs_n,
    output logic                  dac_rw,
    output logic [ADDR_W-1:0]     dac_addr,
    output logic [DATA_W-1:0]     dac_dout,
    output logic                  dac_doe,
    input  logic [DATA_W-1:0]     dac_din,
    output logic                  dac_ldac_n,
    output logic                  dac_reset_n
);

    // Phase lengths in cycles
    localparam int WR_LEN  = max2(max2(ns_to_cyc(T_WR_CS_NS, CLK_PS),
                                       ns_to_cyc(T_LD_SU_NS, CLK_PS)), 1);
    localparam int HD_LEN  = max2(ns_to_cyc(T_LD_HD_NS, CLK_PS), 1);
    localparam int LD_LEN  = max2(ns_to_cyc(T_LD_PW_NS, CLK_PS), 1);
    localparam int RST_LEN = max2(ns_to_cyc(T_RST_NS, CLK_PS), 1);
    localparam int RD_LEN  = max2(max2(ns_to_cyc(T_RD_CS_NS, CLK_PS),
                                       ns_to_cyc(T_RD_ACC_NS, CLK_PS)), 1);
    localparam int GP_LEN  = max2(GAP_CYC, 1);
    localparam int MAX_LEN = max2(max2(max2(WR_LEN, HD_LEN), max2(LD_LEN, RST_LEN)),
                                  max2(RD_LEN, GP_LEN));
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    localparam logic [CNT_W-1:0] WR_LD  = CNT_W'(WR_LEN - 1);
    localparam logic [CNT_W-1:0] HD_LD  = CNT_W'(HD_LEN - 1);
    localparam logic [CNT_W-1:0] LD_LD  = CNT_W'(LD_LEN - 1);
    localparam logic [CNT_W-1:0] RST_LD = CNT_W'(RST_LEN - 1);
    localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_LEN - 1);
    localparam logic [CNT_W-1:0] GP_LD  = CNT_W'(GP_LEN - 1);
    localparam logic [ADDR_W-1:0] LAST_CH = ADDR_W'(NCH - 1);

    state_e              state_q, state_d;
    op_e                 op_q;
    op_e                 req_kind;
    logic                dbl_q;
    logic [ADDR_W-1:0]   chan_q;
    logic                done_q;
    logic [DATA_W-1:0]   rd_q;

    logic                accept;
    logic                finish;
    logic                capture;
    logic                chan_inc;
    logic                more;
    logic                tmr_load;
    logic [CNT_W-1:0]    tmr_val;
    logic                tmr_zero;
    logic [DATA_W-1:0]   stage_word;

    assign req_kind = op_e'(req_op);
    assign more     = (op_q == OP_BATCH) && (chan_q != LAST_CH);

    dacbus_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    dacbus_stage #(
        .DATA_W (DATA_W),
        .NCH    (NCH)
    ) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_all  (accept && (req_kind == OP_BATCH)),
        .cap_one  (accept && (req_kind == OP_WRITE)),
        .cap_sel  (req_chan),
        .one_data (req_data),
        .all_data (req_batch),
        .rd_sel   (chan_q),
        .rd_data  (stage_word)
    );

    // State register and request context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_WRITE;
            dbl_q   <= 1'b0;
            chan_q  <= '0;
            done_q  <= 1'b0;
            rd_q    <= '0;
        end else begin
            state_q <= state_d;
            done_q  <= finish;
            if (accept) begin
                op_q   <= req_kind;
                dbl_q  <= dbl_buf;
                chan_q <= (req_kind == OP_BATCH) ? '0 : req_chan;
            end else if (chan_inc) begin
                chan_q <= chan_q + ADDR_W'(1);
            end
            if (capture) begin
                rd_q <= dac_din;
            end
        end
    end

    // Next state, timer loads and sequencing events
    always_comb begin
        state_d  = state_q;
        accept   = 1'b0;
        finish   = 1'b0;
        capture  = 1'b0;
        chan_inc = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    unique case (req_kind)
                        OP_WRITE, OP_BATCH: begin
                            state_d = ST_WRITE;
                            tmr_val = WR_LD;
                        end
                        OP_READ: begin
                            state_d = ST_READ;
                            tmr_val = RD_LD;
                        end
                        OP_RESET: begin
                            state_d = ST_RESET;
                            tmr_val = RST_LD;
                        end
                        default: state_d = ST_IDLE;
                    endcase
                end
            end
            ST_WRITE: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    if (!dbl_q) begin
                        state_d = ST_LDHOLD;
                        tmr_val = HD_LD;
                    end else if (op_q == OP_BATCH) begin
                        state_d = ST_GAP;
                        tmr_val = GP_LD;
                    end else begin
                        state_d = ST_IDLE;
                        finish  = 1'b1;
                    end
                end
            end
            ST_LDHOLD: begin
                if (tmr_zero) begin
                    if (more) begin
                        state_d  = ST_GAP;
                        tmr_load = 1'b1;
                        tmr_val  = GP_LD;
                    end else begin
                        state_d = ST_IDLE;
                        finish  = 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    if (more) begin
                        state_d  = ST_WRITE;
                        tmr_val  = WR_LD;
                        chan_inc = 1'b1;
                    end else begin
                        state_d = ST_LOAD;
                        tmr_val = LD_LD;
                    end
                end
            end
            ST_LOAD: begin
                if (tmr_zero) begin
                    state_d = ST_IDLE;
                    finish  = 1'b1;
                end
            end
            ST_READ: begin
                if (tmr_zero) begin
                    state_d = ST_IDLE;
                    finish  = 1'b1;
                    capture = 1'b1;
                end
            end
            ST_RESET: begin
                if (tmr_zero) begin
                    state_d = ST_IDLE;
                    finish  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Pin and status decode from the current state
    always_comb begin
        dac_cs_n    = 1'b1;
        dac_rw      = 1'b1;
        dac_doe     = 1'b0;
        dac_ldac_n  = 1'b1;
        dac_reset_n = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_WRITE: begin
                dac_cs_n   = 1'b0;
                dac_rw     = 1'b0;
                dac_doe    = 1'b1;
                dac_ldac_n = dbl_q;
            end
            ST_LDHOLD: begin
                dac_doe    = 1'b1;
                dac_ldac_n = 1'b0;
            end
            ST_GAP: begin
                dac_doe = 1'b1;
            end
            ST_LOAD: begin
                dac_ldac_n = 1'b0;
            end
            ST_READ: begin
                dac_cs_n = 1'b0;
            end
            ST_RESET: begin
                dac_reset_n = 1'b0;
            end
            default: begin
            end
        endcase
    end

    assign dac_addr = chan_q;
    assign dac_dout = stage_word;
    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
    assign rd_data  = rd_q;

endmodule

// File: rtl/dacbus_seq_chk.sv
module dacbus_seq_chk #(
    parameter int AW = 2,
    parameter int DW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dbl_buf,
    input logic          busy,
    input logic          done,
    input logic          dac_cs_n,
    input logic          dac_rw,
    input logic          dac_doe,
    input logic          dac_ldac_n,
    input logic          dac_reset_n,
    input logic [AW-1:0] dac_addr,
    input logic [DW-1:0] dac_dout
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (dac_cs_n && dac_ldac_n && dac_reset_n && !dac_doe));

    assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_cs_n && !$past(dac_cs_n)) |-> ($stable(dac_addr) && $stable(dac_dout)));

    assert_ld_with_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbl_buf && !dac_rw && $fell(dac_cs_n)) |-> !dac_ldac_n);

    assert_no_ld_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl_buf && !dac_cs_n) |-> dac_ldac_n);

    assert_read_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_cs_n && dac_rw) |-> !dac_doe);

    assert_reset_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_reset_n |-> (dac_cs_n && dac_ldac_n));

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_done_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

endmodule

bind dacbus_seq dacbus_seq_chk #(
    .AW ($clog2(NCH)),
    .DW (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dbl_buf     (dbl_buf),
    .busy        (busy),
    .done        (done),
    .dac_cs_n    (dac_cs_n),
    .dac_rw      (dac_rw),
    .dac_doe     (dac_doe),
    .dac_ldac_n  (dac_ldac_n),
    .dac_reset_n (dac_reset_n),
    .dac_addr    (dac_addr),
    .dac_dout    (dac_dout)
);

// File: tb/dacbus_seq_tb.sv
`timescale 1ns/1ps
module dacbus_seq_tb;

    localparam int CLK_PS = 8000;
    localparam int WRC  = (80  * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int LSU  = (70  * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int WRL  = (WRC > LSU) ? WRC : LSU;
    localparam int HDL  = (30  * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int LDPW = (170 * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int RSTC = (140 * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int RDC  = (130 * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int RDA  = (160 * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int RDL  = (RDC > RDA) ? RDC : RDA;
    localparam int GAPC = 2;

    // {op[16:15], dbl[14], chan[13:12], data[11:0]}
    localparam int NV = 12;
    localparam logic [16:0] VEC [NV] = '{
        {2'd3, 1'b0, 2'd0, 12'h000},
        {2'd2, 1'b0, 2'd2, 12'h000},
        {2'd0, 1'b0, 2'd1, 12'h123},
        {2'd0, 1'b1, 2'd3, 12'hABC},
        {2'd2, 1'b1, 2'd3, 12'h000},
        {2'd1, 1'b1, 2'd0, 12'h100},
        {2'd1, 1'b0, 2'd0, 12'hF00},
        {2'd0, 1'b0, 2'd0, 12'hFFF},
        {2'd2, 1'b0, 2'd0, 12'h000},
        {2'd2, 1'b0, 2'd1, 12'h000},
        {2'd3, 1'b1, 2'd0, 12'h000},
        {2'd2, 1'b0, 2'd3, 12'h000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbl_buf = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [1:0]  req_chan = 2'd0;
    logic [11:0] req_data = 12'h000;
    logic [47:0] req_batch = '0;
    logic        busy, done;
    logic [11:0] rd_data;
    logic        dac_cs_n, dac_rw, dac_doe, dac_ldac_n, dac_reset_n;
    logic [1:0]  dac_addr;
    logic [11:0] dac_dout, dac_din;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dacbus_seq u_dut (
        .clk (clk), .rst_n (rst_n), .dbl_buf (dbl_buf),
        .req_valid (req_valid), .req_op (req_op), .req_chan (req_chan),
        .req_data (req_data), .req_batch (req_batch),
        .busy (busy), .done (done), .rd_data (rd_data),
        .dac_cs_n (dac_cs_n), .dac_rw (dac_rw), .dac_addr (dac_addr),
        .dac_dout (dac_dout), .dac_doe (dac_doe), .dac_din (dac_din),
        .dac_ldac_n (dac_ldac_n), .dac_reset_n (dac_reset_n)
    );

    // Behavioural converter model and pin monitor
    logic [11:0] m_in  [4];
    logic [11:0] m_out [4];
    logic [11:0] e_in  [4];
    logic [11:0] e_out [4];
    logic p_cs = 1'b1, p_rw = 1'b1, p_doe = 1'b0, p_ld = 1'b1, p_rst = 1'b1;
    logic [1:0]  p_addr = 2'd0;
    logic [11:0] p_dout = 12'h000;
    int cs_pulses, cs_wmin, cs_wmax, cs_cnt, hi_cnt, gap_min;
    int ld_pulses, ld_w, ld_cnt, rst_w, rst_cnt, wr_n;
    bit overlap, doe_rd;
    int wr_log [4];

    initial begin
        for (int k = 0; k < 4; k++) begin
            m_in[k] = 12'h000; m_out[k] = 12'h000;
            e_in[k] = 12'h000; e_out[k] = 12'h000;
        end
    end

    assign dac_din = (!dac_cs_n && dac_rw) ? m_in[dac_addr] : 12'h000;

    always @(negedge clk) begin
        if (!dac_cs_n) begin
            if (p_cs) begin
                if (cs_pulses > 0 && hi_cnt < gap_min) gap_min = hi_cnt;
                cs_cnt = 1;
            end else begin
                cs_cnt = cs_cnt + 1;
            end
            if (dac_rw && dac_doe) doe_rd = 1;
        end else begin
            if (!p_cs) begin
                cs_pulses = cs_pulses + 1;
                if (cs_cnt < cs_wmin) cs_wmin = cs_cnt;
                if (cs_cnt > cs_wmax) cs_wmax = cs_cnt;
                if (!p_rw) begin
                    m_in[p_addr] = p_doe ? p_dout : 12'hEEE;
                    if (wr_n < 4) wr_log[wr_n] = int'(p_addr);
                    wr_n = wr_n + 1;
                end
                hi_cnt = 1;
            end else begin
                hi_cnt = hi_cnt + 1;
            end
        end
        if (!dac_ldac_n) begin
            ld_cnt = p_ld ? 1 : ld_cnt + 1;
            if (!dac_cs_n) overlap = 1;
            for (int k = 0; k < 4; k++) m_out[k] = m_in[k];
        end else if (!p_ld) begin
            ld_pulses = ld_pulses + 1;
            ld_w = ld_cnt;
        end
        if (!dac_reset_n) begin
            rst_cnt = p_rst ? 1 : rst_cnt + 1;
            for (int k = 0; k < 4; k++) begin
                m_in[k] = 12'h800; m_out[k] = 12'h800;
            end
        end else if (!p_rst) begin
            rst_w = rst_cnt;
        end
        p_cs = dac_cs_n; p_rw = dac_rw; p_doe = dac_doe; p_ld = dac_ldac_n;
        p_rst = dac_reset_n; p_addr = dac_addr; p_dout = dac_dout;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int exp_busy(input logic [1:0] op, input logic db);
        case (op)
            2'd0:    return db ? WRL : WRL + HDL;
            2'd1:    return db ? 4 * WRL + 4 * GAPC + LDPW : 4 * (WRL + HDL) + 3 * GAPC;
            2'd2:    return RDL;
            default: return RSTC;
        endcase
    endfunction

    task automatic run_req(input logic [1:0] op, input logic db, input logic [1:0] ch,
                           input logic [11:0] d, input bit junk);
        int bcnt;
        int guard;
        @(posedge clk); #1;
        cs_pulses = 0; cs_wmin = 9999; cs_wmax = 0; gap_min = 9999;
        ld_pulses = 0; ld_w = 0; rst_w = 0; wr_n = 0; overlap = 0; doe_rd = 0;
        for (int k = 0; k < 4; k++) wr_log[k] = -1;
        dbl_buf = db; req_op = op; req_chan = ch; req_data = d;
        for (int k = 0; k < 4; k++) req_batch[k*12 +: 12] = d + 12'(k * 12'h111);
        req_valid = 1'b1;
        @(posedge clk); #1;
        if (junk) begin
            req_op = 2'd0; req_data = 12'h777;
        end else begin
            req_valid = 1'b0;
        end
        bcnt = 0; guard = 0;
        forever begin
            @(negedge clk);
            if (done) break;
            if (busy) bcnt = bcnt + 1;
            guard = guard + 1;
            if (guard > 2000) begin
                chk("R9 done never seen", 0, 1);
                break;
            end
        end
        req_valid = 1'b0;
        #1;
        // expected state from the requirements
        case (op)
            2'd0: begin e_in[ch] = d; if (!db) e_out[ch] = d; end
            2'd1: for (int k = 0; k < 4; k++) begin
                      e_in[k] = d + 12'(k * 12'h111); e_out[k] = e_in[k];
                  end
            2'd3: for (int k = 0; k < 4; k++) begin
                      e_in[k] = 12'h800; e_out[k] = 12'h800;
                  end
            default: begin end
        endcase
        chk("R9 busy cycles", bcnt, exp_busy(op, db));
        case (op)
            2'd0, 2'd1: begin
                chk("R2 select pulses", cs_pulses, (op == 2'd1) ? 4 : 1);
                chk("R2 select width min", cs_wmin, WRL);
                chk("R2 select width max", cs_wmax, WRL);
                if (op == 2'd1) begin
                    for (int k = 0; k < 4; k++) chk("R5 address order", wr_log[k], k);
                    chk("R5 gap between channels", gap_min, db ? GAPC : HDL + GAPC);
                end
                if (!db) begin
                    chk("R3 strobe pulses", ld_pulses, (op == 2'd1) ? 4 : 1);
                    chk("R3 strobe width", ld_w, WRL + HDL);
                end else if (op == 2'd0) begin
                    chk("R4 no strobe in double-buffer write", ld_pulses, 0);
                end else begin
                    chk("R6 single load pulse", ld_pulses, 1);
                    chk("R6 load width", ld_w, LDPW);
                    chk("R6 load apart from select", int'(overlap), 0);
                end
            end
            2'd2: begin
                chk("R7 read width", cs_wmin, RDL);
                chk("R7 bus released", int'(doe_rd), 0);
                chk("R7 read value", int'(rd_data), int'(e_in[ch]));
                chk("R7 no strobe", ld_pulses, 0);
            end
            default: begin
                chk("R8 reset width", rst_w, RSTC);
                chk("R8 no select", cs_pulses, 0);
            end
        endcase
        for (int k = 0; k < 4; k++) begin
            chk((op == 2'd0 && db) ? "R4 output held" : "R2 output value",
                int'(m_out[k]), int'(e_out[k]));
            chk("R2 input register", int'(m_in[k]), int'(e_in[k]));
        end
    endtask

    task automatic idle_check(input string tag);
        chk({tag, " cs_n"}, int'(dac_cs_n), 1);
        chk({tag, " ldac_n"}, int'(dac_ldac_n), 1);
        chk({tag, " reset_n"}, int'(dac_reset_n), 1);
        chk({tag, " doe"}, int'(dac_doe), 0);
        chk({tag, " busy"}, int'(busy), 0);
        chk({tag, " done"}, int'(done), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        idle_check("R1 reset state");
        for (int v = 0; v < NV; v++) begin
            run_req(VEC[v][16:15], VEC[v][14], VEC[v][13:12], VEC[v][11:0], 1'b0);
        end
        // R10: request held high while busy must be ignored
        run_req(2'd0, 1'b0, 2'd2, 12'h555, 1'b1);
        repeat (3) @(negedge clk);
        chk("R10 no extra select", cs_pulses, 1);
        run_req(2'd2, 1'b0, 2'd2, 12'h000, 1'b0);
        chk("R10 readback after ignored request", int'(rd_data), 12'h555);
        @(negedge clk);
        idle_check("R1 idle at end");
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL R9 watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule